// File: doc/BRIEF.md
# Two-Pulse Isolated Gate Drive Sequencer

This block drives a pulse-transformer gate stage. The power switch's gate capacitance holds the on or off level. The block sends a short "turn-on" pulse on one line and a short "turn-off" pulse on the other, so the time between them sets the effective duty cycle. One triangle counter produces both pulses. The counter rises from 0 to a half-period limit and then falls back to 0. A two-phase sequencer places the turn-on pulse in the rising half and the turn-off pulse in the falling half. The two pulses sit symmetrically about the turning point.

A 10-bit duty command with a valid strobe is scaled linearly into a low compare value. The high compare value is always the low value plus the pulse width. A new command only arms an update. The armed value moves into a shadow pair at the top of the triangle and into the live pair at the bottom. The live pair therefore never changes in the middle of a half. After reset the live pair lies beyond the limit, so no pulse appears until a command has been applied. A falling edge on the start line sets the counter running. A low stop level, seen when the counter returns to zero, halts the counter cleanly.

Top module: `twin_pulse_gate_drv`

## Requirements
- R1: After reset both pulse lines, `phase` and `half_evt` are 0. While the compare pair still holds its reset value, no pulse appears in any half, even with the counter running.
- R2: The counter starts only on a falling edge of `start_in` (1 then 0). Before the start edge, and while halted, it rests at zero: no `half_evt`, and both pulse lines stay low. A low level on `start_in` without a new edge does not restart it. An edge while the counter runs has no effect.
- R3: While running, `phase` = 0 (rising half) lasts HALF_PERIOD cycles and `phase` = 1 (falling half) lasts HALF_PERIOD cycles. The one exception is the first rising half after a start, which lasts one cycle longer. `half_evt` is a one-cycle pulse in the first cycle of each falling half.
- R4: `pulse_a` rises HALF_PERIOD − lo cycles before `half_evt` and stays high for exactly PULSE_W cycles. It is high only in the rising half.
- R5: `pulse_b` rises HALF_PERIOD − hi cycles after `half_evt`, where hi = lo + PULSE_W. It stays high for exactly PULSE_W cycles, only in the falling half.
- R6: The command sets lo = LO_MIN + (((LO_MAX − LO_MIN) × cmd) >> CMD_W).
- R7: A command strobed during a rising half changes nothing in that period. It takes effect in both pulses from the next period on.
- R8: When several commands arrive before one turning point, only the last one is applied. An applied value stays in force until another command arrives.
- R9: If `stop_n` is 0 when the counter reaches zero at the end of a falling half, the counter halts at zero, `phase` becomes 0 and both pulse lines go low. A low `stop_n` at any other time does not disturb the current period.
- R10: The compare reload at the halting zero still takes place. After a restart, the pulses use the value that was armed before the halt.
- R11: `pulse_a` and `pulse_b` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_in | input | 1 | Start request; a falling edge starts the counter |
| stop_n | input | 1 | Active-low stop level, sampled at the bottom of the triangle |
| cmd | input | CMD_W | Duty command |
| cmd_valid | input | 1 | One-cycle strobe that takes `cmd` |
| pulse_a | output | 1 | Turn-on pulse, rising half |
| pulse_b | output | 1 | Turn-off pulse, falling half |
| phase | output | 1 | 0 = rising half, 1 = falling half |
| half_evt | output | 1 | One-cycle flag at the turning point |

## Verification
The bench builds the block with HALF_PERIOD = 40, PULSE_W = 4, LO_MIN = 2 and LO_MAX = 30, so a full period takes 80 cycles. With these values the smallest, middle and largest commands, several command overrides, and a stop followed by a restart all fit in a few thousand cycles. They also reach both extremes of the compare range: lo = 2 puts the pulses next to the bottom turning point, and hi = 33 puts them close to the top one. The scoreboard measures every pulse position against `half_evt`, so any slip of one cycle in either pulse is reported.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } phase_e;
endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tpg_scale.sv
// Linear map of the duty command onto the low compare value (R6).
module tpg_scale #(
  parameter int CMD_W  = 10,
  parameter int CNT_W  = 16,
  parameter int LO_MIN = 36,
  parameter int LO_MAX = 1116
) (
  input  logic [CMD_W-1:0] cmd,
  output logic [CNT_W-1:0] lo
);
  localparam int SPAN   = LO_MAX - LO_MIN;
  localparam int PROD_W = CMD_W + CNT_W;

  logic [PROD_W-1:0] prod;

  assign prod = PROD_W'(SPAN) * PROD_W'(cmd);
  assign lo   = CNT_W'(LO_MIN) + CNT_W'(prod >> CMD_W);
endmodule

// File: rtl/tpg_cmp_bank.sv
// Pending / shadow / live compare pairs with top-load and bottom-reload.
module tpg_cmp_bank #(
  parameter int CNT_W       = 16,
  parameter int HALF_PERIOD = 1200,
  parameter int PULSE_W     = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_lo,
  input  logic             take_ev,
  input  logic             zero_ev,
  output logic [CNT_W-1:0] live_lo,
  output logic [CNT_W-1:0] live_hi
);
  localparam logic [CNT_W-1:0] PARK_LO = CNT_W'(HALF_PERIOD + 1);
  localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(PULSE_W);

  logic [CNT_W-1:0] pend_q, pend_n;
  logic             armed_q, armed_n;
  logic [CNT_W-1:0] sh_lo_q, sh_lo_n, sh_hi_q, sh_hi_n;
  logic [CNT_W-1:0] lv_lo_q, lv_lo_n, lv_hi_q, lv_hi_n;
  logic             pend_en, sh_en, lv_en;

  assign pend_en = cmd_valid;
  assign sh_en   = take_ev & armed_q;
  assign lv_en   = zero_ev;

  always_comb begin
    pend_n  = cmd_lo;
    sh_lo_n = pend_q;
    sh_hi_n = pend_q + WIDTH_C;
    lv_lo_n = sh_lo_q;
    lv_hi_n = sh_hi_q;
    if (cmd_valid)    armed_n = 1'b1;
    else if (sh_en)   armed_n = 1'b0;
    else              armed_n = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= PARK_LO;
      armed_q <= 1'b0;
      sh_lo_q <= PARK_LO;
      sh_hi_q <= PARK_LO + WIDTH_C;
      lv_lo_q <= PARK_LO;
      lv_hi_q <= PARK_LO + WIDTH_C;
    end else begin
      if (pend_en) pend_q <= pend_n;
      armed_q <= armed_n;
      if (sh_en) begin
        sh_lo_q <= sh_lo_n;
        sh_hi_q <= sh_hi_n;
      end
      if (lv_en) begin
        lv_lo_q <= lv_lo_n;
        lv_hi_q <= lv_hi_n;
      end
    end
  end

  assign live_lo = lv_lo_q;
  assign live_hi = lv_hi_q;

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_ev |=> ($stable(live_lo) && $stable(live_hi))); // R7

  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && armed_q && !cmd_valid) |=> !armed_q); // R8

  AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !take_ev |=> ($stable(sh_lo_q) && $stable(sh_hi_q))); // R7
endmodule

// File: rtl/tpg_sequencer.sv
// Triangle counter, two-phase state and pulse outputs.
module tpg_sequencer
  import tpg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HALF_PERIOD = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_in,
  input  logic             stop_n,
  input  logic [CNT_W-1:0] live_lo,
  input  logic [CNT_W-1:0] live_hi,
  output logic             pulse_a,
  output logic             pulse_b,
  output logic             phase,
  output logic             half_evt,
  output logic             take_ev,
  output logic             zero_ev
);
  localparam logic [CNT_W-1:0] TOP_C = CNT_W'(HALF_PERIOD);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  phase_e           ph_q, ph_n;
  logic             run_q, run_n;
  logic             pa_q, pa_n, pb_q, pb_n;
  logic             start_q, half_q;
  logic             start_fall, top_hit, halt;
  logic             cnt_en;

  assign start_fall = start_q & ~start_in;
  assign top_hit    = run_q && (ph_q == PH_RISE) && (cnt_q == TOP_C);
  assign zero_ev    = run_q && (ph_q == PH_FALL) && (cnt_q == '0);
  assign halt       = zero_ev && !stop_n;
  assign take_ev    = top_hit;
  assign cnt_en     = run_q;

  always_comb begin
    cnt_n = cnt_q;
    ph_n  = ph_q;
    run_n = run_q;
    pa_n  = pa_q;
    pb_n  = pb_q;
    if (!run_q) begin
      if (start_fall) run_n = 1'b1;
    end else begin
      unique case (ph_q)
        PH_RISE: begin
          if (cnt_q == live_lo) pa_n = 1'b1;
          if (cnt_q == live_hi) pa_n = 1'b0;
          if (top_hit) begin
            ph_n  = PH_FALL;
            cnt_n = cnt_q - ONE_C;
          end else begin
            cnt_n = cnt_q + ONE_C;
          end
        end
        PH_FALL: begin
          if (cnt_q == live_hi) pb_n = 1'b1;
          if (cnt_q == live_lo) pb_n = 1'b0;
          if (zero_ev) begin
            ph_n = PH_RISE;
            if (halt) begin
              run_n = 1'b0;
              cnt_n = '0;
              pa_n  = 1'b0;
              pb_n  = 1'b0;
            end else begin
              cnt_n = ONE_C;
            end
          end else begin
            cnt_n = cnt_q - ONE_C;
          end
        end
        default: ph_n = PH_RISE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ph_q    <= PH_RISE;
      run_q   <= 1'b0;
      pa_q    <= 1'b0;
      pb_q    <= 1'b0;
      start_q <= 1'b1;
      half_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_n;
      ph_q    <= ph_n;
      run_q   <= run_n;
      pa_q    <= pa_n;
      pb_q    <= pb_n;
      start_q <= start_in;
      half_q  <= top_hit;
    end
  end

  assign pulse_a  = pa_q;
  assign pulse_b  = pb_q;
  assign phase    = ph_q;
  assign half_evt = half_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP_C); // R3

  AST_HALF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt |=> !half_evt); // R3

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_a && pulse_b)); // R11

  AST_A_IN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_a |-> (phase == 1'b0)); // R4

  AST_B_IN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_b |-> (phase == 1'b1)); // R5

  AST_A_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_a) |-> ($past(cnt_q) == live_lo)); // R4

  AST_HALT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!run_q && cnt_q == '0 && !pulse_a && !pulse_b && phase == 1'b0)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!pulse_a && !pulse_b && !half_evt)); // R2
endmodule

// File: rtl/twin_pulse_gate_drv.sv
module twin_pulse_gate_drv #(
  parameter int CNT_W       = 16,
  parameter int CMD_W       = 10,
  parameter int HALF_PERIOD = 1200,
  parameter int PULSE_W     = 48,
  parameter int LO_MIN      = 36,
  parameter int LO_MAX      = 1116
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_in,
  input  logic             stop_n,
  input  logic [CMD_W-1:0] cmd,
  input  logic             cmd_valid,
  output logic             pulse_a,
  output logic             pulse_b,
  output logic             phase,
  output logic             half_evt
);
  logic             rst_int_n;
  logic [CNT_W-1:0] cmd_lo, live_lo, live_hi;
  logic             take_ev, zero_ev;

  tpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tpg_scale #(
    .CMD_W (CMD_W), .CNT_W (CNT_W), .LO_MIN (LO_MIN), .LO_MAX (LO_MAX)
  ) u_scale (
    .cmd (cmd),
    .lo  (cmd_lo)
  );

  tpg_cmp_bank #(
    .CNT_W (CNT_W), .HALF_PERIOD (HALF_PERIOD), .PULSE_W (PULSE_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_lo    (cmd_lo),
    .take_ev   (take_ev),
    .zero_ev   (zero_ev),
    .live_lo   (live_lo),
    .live_hi   (live_hi)
  );

  tpg_sequencer #(
    .CNT_W (CNT_W), .HALF_PERIOD (HALF_PERIOD)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_in (start_in),
    .stop_n   (stop_n),
    .live_lo  (live_lo),
    .live_hi  (live_hi),
    .pulse_a  (pulse_a),
    .pulse_b  (pulse_b),
    .phase    (phase),
    .half_evt (half_evt),
    .take_ev  (take_ev),
    .zero_ev  (zero_ev)
  );
endmodule

// File: tb/twin_pulse_gate_drv_tb_top.sv
`timescale 1ns/1ps
module twin_pulse_gate_drv_tb_top;
  localparam int HALF = 40;
  localparam int W    = 4;
  localparam int LMIN = 2;
  localparam int LMAX = 30;
  localparam int CW   = 10;

  logic clk = 1'b0;
  logic rst_n, start_in, stop_n, cmd_valid;
  logic [CW-1:0] cmd;
  logic pulse_a, pulse_b, phase, half_evt;

  always #2.5 clk = ~clk;

  twin_pulse_gate_drv #(
    .CNT_W (16), .CMD_W (CW), .HALF_PERIOD (HALF), .PULSE_W (W),
    .LO_MIN (LMIN), .LO_MAX (LMAX)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start_in (start_in), .stop_n (stop_n),
    .cmd (cmd), .cmd_valid (cmd_valid), .pulse_a (pulse_a), .pulse_b (pulse_b),
    .phase (phase), .half_evt (half_evt)
  );

  typedef struct {
    bit    line;
    bit    present;
    int    lo;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   closing = 0;

  // bench-side model of the compare pipeline, kept at period granularity
  int m_pend = 0, m_sh = 0, m_live = 0;
  bit m_armed = 0, m_sh_ok = 0, m_live_ok = 0;
  string m_tag = "R1";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!closing) begin
      closing = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int scale(input int c);
    return LMIN + (((LMAX - LMIN) * c) >> CW);
  endfunction

  // ---------------- monitor ----------------
  int cyc = 0, h_cyc = 0, halves = 0, overlap = 0;
  int a_rise = 0, a_wid = 0, b_rise = 0, b_wid = 0;
  bit a_seen = 0, b_seen = 0, a_q = 0, b_q = 0, ph_q = 0;

  always @(negedge clk) begin
    exp_t it;
    cyc++;
    if (pulse_a === 1'b1 && pulse_b === 1'b1) overlap++;
    if (pulse_a === 1'b1 && !a_q) begin a_rise = cyc; a_seen = 1; end
    if (pulse_a === 1'b0 && a_q)  a_wid = cyc - a_rise;
    if (pulse_b === 1'b1 && !b_q) begin b_rise = cyc; b_seen = 1; end
    if (pulse_b === 1'b0 && b_q)  b_wid = cyc - b_rise;
    if (half_evt === 1'b1) begin
      h_cyc = cyc;
      halves++;
      if (exp_q.size() == 0 || exp_q[0].line != 1'b0) begin
        check(0, "R3 unexpected turning point", halves, 0);
      end else begin
        it = exp_q.pop_front();
        if (it.present) begin
          check(a_seen, {it.tag, " R4 pulse A present"}, a_seen, 1);
          check(h_cyc - a_rise == HALF - it.lo, {it.tag, " R4 pulse A lead"},
                h_cyc - a_rise, HALF - it.lo);
          check(a_wid == W, "R4 pulse A width", a_wid, W);
        end else begin
          check(!a_seen, {it.tag, " pulse A absent"}, a_seen, 0);
        end
      end
      a_seen = 0;
    end
    if (ph_q && phase === 1'b0) begin
      check(cyc - h_cyc == HALF, "R3 falling half length", cyc - h_cyc, HALF);
      if (exp_q.size() == 0 || exp_q[0].line != 1'b1) begin
        check(0, "R5 unexpected falling half end", 0, 1);
      end else begin
        it = exp_q.pop_front();
        if (it.present) begin
          check(b_seen, {it.tag, " R5 pulse B present"}, b_seen, 1);
          check(b_rise - h_cyc == HALF - (it.lo + W), {it.tag, " R5 pulse B lag"},
                b_rise - h_cyc, HALF - (it.lo + W));
          check(b_wid == W, "R5 pulse B width", b_wid, W);
        end else begin
          check(!b_seen, {it.tag, " pulse B absent"}, b_seen, 0);
        end
      end
      b_seen = 0;
    end
    a_q  = (pulse_a === 1'b1);
    b_q  = (pulse_b === 1'b1);
    ph_q = (phase === 1'b1);
  end

  // ---------------- driver ----------------
  task automatic send_cmd(input int c);
    cmd       = CW'(c);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    m_pend  = scale(c);
    m_armed = 1;
  endtask

  task automatic do_period(input bit do_stop);
    exp_q.push_back('{1'b0, m_live_ok, m_live, m_tag});
    if (m_armed) begin m_sh = m_pend; m_sh_ok = 1; m_armed = 0; end
    exp_q.push_back('{1'b1, m_live_ok, m_live, m_tag});
    m_live = m_sh; m_live_ok = m_sh_ok;
    if (do_stop) stop_n = 1'b0;
    while (phase !== 1'b1) @(negedge clk);
    while (phase !== 1'b0) @(negedge clk);
  endtask

  task automatic start_edge();
    start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
    @(negedge clk);
    start_in = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_sim();
  end

  initial begin
    int h0;
    rst_n = 1'b0; start_in = 1'b1; stop_n = 1'b1; cmd = '0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(pulse_a === 1'b0 && pulse_b === 1'b0, "R1 pulses after reset", pulse_a | pulse_b, 0);
    check(phase === 1'b0 && half_evt === 1'b0, "R1 phase/flag after reset", phase | half_evt, 0);
    // R2 no activity before a start edge
    repeat (100) @(negedge clk);
    check(halves == 0 && !a_seen && !b_seen, "R2 idle before start", halves, 0);

    start_edge();
    m_tag = "R1";
    do_period(0);
    do_period(0);

    // R6 R7: mid command, applied from the following period
    send_cmd(512); m_tag = "R7"; do_period(0);
    m_tag = "R6"; do_period(0); do_period(0);
    // extremes of the range
    send_cmd(0);    m_tag = "R7"; do_period(0);
    m_tag = "R6"; do_period(0);
    send_cmd(1023); m_tag = "R7"; do_period(0);
    m_tag = "R6"; do_period(0); do_period(0);
    // R8: last of two commands wins, then holds
    send_cmd(300); send_cmd(512); m_tag = "R8"; do_period(0);
    do_period(0); do_period(0);

    // R9 R10: stop low early in the period; start low level plus a spurious edge
    send_cmd(300);
    start_in = 1'b0;
    m_tag = "R9"; do_period(1);
    h0 = halves;
    repeat (3 * HALF) begin
      @(negedge clk);
      if (pulse_a !== 1'b0 || pulse_b !== 1'b0 || phase !== 1'b0) begin
        check(0, "R9 halted outputs low", {pulse_a, pulse_b, phase}, 0);
        break;
      end
    end
    check(halves == h0, "R2 R9 no restart on low level", halves - h0, 0);
    stop_n = 1'b1;
    start_edge();
    m_tag = "R10"; do_period(0); do_period(0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    check(overlap == 0, "R11 pulse overlap cycles", overlap, 0);
    finish_sim();
  end
endmodule